// File: doc/BRIEF.md
# SRAM Access Phase Sequencer

This block is the timing brain in front of a bitline-style SRAM array. It accepts read and write requests and turns each one into an ordered run of control strobes. A read precharges and equalizes the bitline pairs. The wordline then opens and is held for a programmable number of cycles while bitline swing builds up. Finally the sense amplifier is fired, with the bitlines isolated from it. A write turns the bitline drivers on first and raises the wordline only after that. The analog cells, bitlines and sense amplifiers sit outside the block.

The block has two modes. In single mode each sequence serves one access, and a port A read wins over a write. In dual mode one sequence serves up to two reads in its first phase (ports A and B, each on its own wordline) and one write in its second phase, with the write on the port A wordline. A read of the same row as the write therefore returns the value held before the write.

A requester raises its request and holds it, along with its address, until it sees its one-cycle grant. Requests that arrive while a sequence runs are taken up when the sequencer is next idle.

Top module: `sram_phase_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every strobe, `rdy`, `wr_phase` and every grant is low.
- R2: A read sequence starts with exactly one precharge cycle. The read wordlines (`wl_en_a` for a port A read, `wl_en_b` for a port B read) are then high for exactly N consecutive cycles, starting in the cycle right after precharge.
- R3: A write sequence drives `wdrv_en` alone for one cycle. It then raises `wl_en_a` with `wl_row_a` set to the write row for N cycles while `wdrv_en` stays high.
- R4: The cycle after the last read-wordline cycle has `sa_clk` and `iso_en` high and both wordlines low. `sa_clk` is never high in any other cycle.
- R5: N is `swing_cycles`, sampled when the sequence is launched. A value of 0 is used as 1.
- R6: `rdy` is high for exactly one cycle, in the cycle after the last strobe of a sequence, and no strobe is high in that cycle.
- R7: In single mode (`dual_mode`=0) a port A read has priority over a write, and `rd_b_req` is ignored: it produces no grant and no strobe.
- R8: In dual mode the reads run first and the write follows in the same sequence. The write runs right after the sense cycle, and `wr_phase` is high during exactly the write-driver and write-wordline cycles.
- R9: In dual mode, a read of the same row the write targets returns the data stored before the write.
- R10: Grants are one-cycle pulses, given in the first cycle of the sequence that serves the port. A request still held when a sequence ends is granted two cycles after that sequence's `rdy`, so no request is lost.
- R11: `pch_en` is never high in the same cycle as a wordline, nor in the cycle right after one.

Sequence lengths: a read-only sequence lasts N+2 cycles plus the `rdy` cycle, a write-only sequence lasts N+1 plus `rdy`, and a combined sequence lasts 2N+3 plus `rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dual_mode | input | 1 | 1: two reads plus one write per sequence; 0: one access per sequence |
| rd_a_req | input | 1 | Port A read request, held until `grant_a` |
| rd_a_addr | input | AW | Port A read row |
| rd_b_req | input | 1 | Port B read request (dual mode only), held until `grant_b` |
| rd_b_addr | input | AW | Port B read row |
| wr_req | input | 1 | Write request, held until `grant_w` |
| wr_addr | input | AW | Write row |
| swing_cycles | input | CW | Wordline-on cycles before sensing; 0 is taken as 1 |
| pch_en | output | 1 | Bitline precharge and equalize |
| wl_en_a | output | 1 | Port A wordline enable (reads on A and all writes) |
| wl_row_a | output | AW | Row on the port A wordline, 0 when it is off |
| wl_en_b | output | 1 | Port B wordline enable |
| wl_row_b | output | AW | Row on the port B wordline, 0 when it is off |
| wdrv_en | output | 1 | Write-driver enable on the bitline pair |
| sa_clk | output | 1 | Sense-amplifier fire |
| iso_en | output | 1 | Bitline-to-sense-amplifier isolation |
| wr_phase | output | 1 | High during the write half of a sequence |
| rdy | output | 1 | One-cycle completion pulse |
| grant_a | output | 1 | Port A request taken |
| grant_b | output | 1 | Port B request taken |
| grant_w | output | 1 | Write request taken |

## Verification
Each strobe is decoded from a registered state. A request seen at one clock edge therefore shows its grant and its first strobe in the cycle that follows, and every later strobe falls at a fixed offset from that first cycle, set by N and by which ports were taken. For every sequence the bench computes the whole expected strobe pattern cycle by cycle, starting at the first cycle. It samples all outputs on the falling edge of each of those cycles and compares them with that pattern, including the idle cycle expected between chained sequences. Read data comes from a behavioural array in the bench. That array captures the row at sense time and writes while the driver and the wordline are both on, so the same-row read-before-write case is checked through the data it returns.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_RWL   = 3'd2,
        ST_SENSE = 3'd3,
        ST_WDRV  = 3'd4,
        ST_WWL   = 3'd5,
        ST_FIN   = 3'd6
    } seq_state_e;

endpackage

// File: rtl/sps_req_latch.sv
module sps_req_latch #(
    parameter int AW = 6,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          dual_mode,
    input  logic          rd_a_req,
    input  logic [AW-1:0] rd_a_addr,
    input  logic          rd_b_req,
    input  logic [AW-1:0] rd_b_addr,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] swing_cycles,
    output logic          any_req,
    output logic          sel_rd,
    output logic          take_a,
    output logic          take_b,
    output logic          take_w,
    output logic [AW-1:0] row_a,
    output logic [AW-1:0] row_b,
    output logic [AW-1:0] row_w,
    output logic [CW-1:0] swing_eff,
    output logic          grant_a,
    output logic          grant_b,
    output logic          grant_w
);

    typedef struct packed {
        logic          ta;
        logic          tb;
        logic          tw;
        logic [AW-1:0] ra;
        logic [AW-1:0] rb;
        logic [AW-1:0] rw;
        logic [CW-1:0] sw;
        logic          ga;
        logic          gb;
        logic          gw;
    } latch_t;

    latch_t lat_d, lat_q;
    logic   sel_a, sel_b, sel_w;

    always_comb begin
        sel_a   = rd_a_req;
        sel_b   = dual_mode & rd_b_req;
        sel_w   = wr_req & (dual_mode | ~rd_a_req);
        any_req = sel_a | sel_b | sel_w;
        sel_rd  = sel_a | sel_b;

        lat_d    = lat_q;
        lat_d.ga = 1'b0;
        lat_d.gb = 1'b0;
        lat_d.gw = 1'b0;
        if (launch) begin
            lat_d.ta = sel_a;
            lat_d.tb = sel_b;
            lat_d.tw = sel_w;
            lat_d.ra = rd_a_addr;
            lat_d.rb = rd_b_addr;
            lat_d.rw = wr_addr;
            lat_d.sw = (swing_cycles == '0) ? CW'(1) : swing_cycles;
            lat_d.ga = sel_a;
            lat_d.gb = sel_b;
            lat_d.gw = sel_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign take_a    = lat_q.ta;
    assign take_b    = lat_q.tb;
    assign take_w    = lat_q.tw;
    assign row_a     = lat_q.ra;
    assign row_b     = lat_q.rb;
    assign row_w     = lat_q.rw;
    assign swing_eff = lat_q.sw;
    assign grant_a   = lat_q.ga;
    assign grant_b   = lat_q.gb;
    assign grant_w   = lat_q.gw;

endmodule

// File: rtl/sps_swing_timer.sv
module sps_swing_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    output logic          last
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (step && tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign last = (tmr_q.cnt == CW'(1));

endmodule

// File: rtl/sps_fsm.sv
module sps_fsm
    import sps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_req,
    input  logic       sel_rd,
    input  logic       take_w,
    input  logic       timer_last,
    output seq_state_e state,
    output logic       launch,
    output logic       load_timer,
    output logic       step_timer
);

    typedef struct packed {
        seq_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d      = fsm_q;
        launch     = 1'b0;
        load_timer = 1'b0;
        step_timer = 1'b0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (any_req) begin
                    launch   = 1'b1;
                    fsm_d.st = sel_rd ? ST_PRE : ST_WDRV;
                end
            end
            ST_PRE: begin
                load_timer = 1'b1;
                fsm_d.st   = ST_RWL;
            end
            ST_RWL: begin
                step_timer = 1'b1;
                if (timer_last) fsm_d.st = ST_SENSE;
            end
            ST_SENSE: begin
                fsm_d.st = take_w ? ST_WDRV : ST_FIN;
            end
            ST_WDRV: begin
                load_timer = 1'b1;
                fsm_d.st   = ST_WWL;
            end
            ST_WWL: begin
                step_timer = 1'b1;
                if (timer_last) fsm_d.st = ST_FIN;
            end
            ST_FIN: begin
                fsm_d.st = ST_IDLE;
            end
            default: begin
                fsm_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state = fsm_q.st;

endmodule

// File: rtl/sps_strobe_dec.sv
module sps_strobe_dec
    import sps_pkg::*;
#(
    parameter int AW = 6
) (
    input  seq_state_e    state,
    input  logic          take_a,
    input  logic          take_b,
    input  logic [AW-1:0] row_a,
    input  logic [AW-1:0] row_b,
    input  logic [AW-1:0] row_w,
    output logic          pch_en,
    output logic          wl_en_a,
    output logic [AW-1:0] wl_row_a,
    output logic          wl_en_b,
    output logic [AW-1:0] wl_row_b,
    output logic          wdrv_en,
    output logic          sa_clk,
    output logic          iso_en,
    output logic          wr_phase,
    output logic          rdy
);

    always_comb begin
        pch_en   = 1'b0;
        wl_en_a  = 1'b0;
        wl_row_a = '0;
        wl_en_b  = 1'b0;
        wl_row_b = '0;
        wdrv_en  = 1'b0;
        sa_clk   = 1'b0;
        iso_en   = 1'b0;
        wr_phase = 1'b0;
        rdy      = 1'b0;
        unique case (state)
            ST_PRE: pch_en = 1'b1;
            ST_RWL: begin
                wl_en_a  = take_a;
                wl_row_a = take_a ? row_a : '0;
                wl_en_b  = take_b;
                wl_row_b = take_b ? row_b : '0;
            end
            ST_SENSE: begin
                sa_clk = 1'b1;
                iso_en = 1'b1;
            end
            ST_WDRV: begin
                wdrv_en  = 1'b1;
                wr_phase = 1'b1;
            end
            ST_WWL: begin
                wdrv_en  = 1'b1;
                wr_phase = 1'b1;
                wl_en_a  = 1'b1;
                wl_row_a = row_w;
            end
            ST_FIN:  rdy = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
    import sps_pkg::*;
#(
    parameter int AW = 6,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual_mode,
    input  logic          rd_a_req,
    input  logic [AW-1:0] rd_a_addr,
    input  logic          rd_b_req,
    input  logic [AW-1:0] rd_b_addr,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] swing_cycles,
    output logic          pch_en,
    output logic          wl_en_a,
    output logic [AW-1:0] wl_row_a,
    output logic          wl_en_b,
    output logic [AW-1:0] wl_row_b,
    output logic          wdrv_en,
    output logic          sa_clk,
    output logic          iso_en,
    output logic          wr_phase,
    output logic          rdy,
    output logic          grant_a,
    output logic          grant_b,
    output logic          grant_w
);

    seq_state_e    state;
    logic          launch, load_timer, step_timer, timer_last;
    logic          any_req, sel_rd, take_a, take_b, take_w;
    logic [AW-1:0] row_a, row_b, row_w;
    logic [CW-1:0] swing_eff;

    sps_req_latch #(.AW(AW), .CW(CW)) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .dual_mode    (dual_mode),
        .rd_a_req     (rd_a_req),
        .rd_a_addr    (rd_a_addr),
        .rd_b_req     (rd_b_req),
        .rd_b_addr    (rd_b_addr),
        .wr_req       (wr_req),
        .wr_addr      (wr_addr),
        .swing_cycles (swing_cycles),
        .any_req      (any_req),
        .sel_rd       (sel_rd),
        .take_a       (take_a),
        .take_b       (take_b),
        .take_w       (take_w),
        .row_a        (row_a),
        .row_b        (row_b),
        .row_w        (row_w),
        .swing_eff    (swing_eff),
        .grant_a      (grant_a),
        .grant_b      (grant_b),
        .grant_w      (grant_w)
    );

    sps_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_req    (any_req),
        .sel_rd     (sel_rd),
        .take_w     (take_w),
        .timer_last (timer_last),
        .state      (state),
        .launch     (launch),
        .load_timer (load_timer),
        .step_timer (step_timer)
    );

    sps_swing_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_timer),
        .load_val (swing_eff),
        .step     (step_timer),
        .last     (timer_last)
    );

    sps_strobe_dec #(.AW(AW)) u_dec (
        .state    (state),
        .take_a   (take_a),
        .take_b   (take_b),
        .row_a    (row_a),
        .row_b    (row_b),
        .row_w    (row_w),
        .pch_en   (pch_en),
        .wl_en_a  (wl_en_a),
        .wl_row_a (wl_row_a),
        .wl_en_b  (wl_en_b),
        .wl_row_b (wl_row_b),
        .wdrv_en  (wdrv_en),
        .sa_clk   (sa_clk),
        .iso_en   (iso_en),
        .wr_phase (wr_phase),
        .rdy      (rdy)
    );

endmodule

// File: rtl/sps_seq_checker.sv
module sps_seq_checker #(
    parameter int CW = 4
) (
    input logic clk,
    input logic rst_n,
    input logic pch_en,
    input logic wl_en_a,
    input logic wl_en_b,
    input logic wdrv_en,
    input logic sa_clk,
    input logic iso_en,
    input logic wr_phase,
    input logic rdy
);

    logic [CW:0] wl_run_q;
    logic        wl_any;

    assign wl_any = wl_en_a | wl_en_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wl_run_q <= '0;
        end else if (!wl_any) begin
            wl_run_q <= '0;
        end else if (wl_run_q != '1) begin
            wl_run_q <= wl_run_q + 1'b1;
        end
    end

    AST_PCH_WL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pch_en && wl_any)); // R11

    AST_PCH_AFTER_WL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pch_en) |-> !$past(wl_en_a) && !$past(wl_en_b)); // R11

    AST_RD_WL_AFTER_PCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wl_en_a) || $rose(wl_en_b)) && !wdrv_en |-> $past(pch_en)); // R2

    AST_WR_DRV_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wl_en_a) && wdrv_en |-> $past(wdrv_en) && !$past(wl_en_a)); // R3

    AST_SA_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        sa_clk |-> iso_en && !wl_any && !wdrv_en); // R4

    AST_SA_AFTER_SWING: assert property (@(posedge clk) disable iff (!rst_n)
        sa_clk |-> wl_run_q != '0); // R4

    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy); // R6

    AST_RDY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> !pch_en && !wl_any && !wdrv_en && !sa_clk); // R6

    AST_WR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        wdrv_en |-> wr_phase && !pch_en); // R8

endmodule

bind sram_phase_seq sps_seq_checker #(.CW(CW)) u_sps_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pch_en   (pch_en),
    .wl_en_a  (wl_en_a),
    .wl_en_b  (wl_en_b),
    .wdrv_en  (wdrv_en),
    .sa_clk   (sa_clk),
    .iso_en   (iso_en),
    .wr_phase (wr_phase),
    .rdy      (rdy)
);

// File: tb/tb_sram_phase_seq.sv
`timescale 1ns/1ps
module tb_sram_phase_seq;

    localparam int AW = 6;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dual_mode = 1'b0;
    logic          rd_a_req = 1'b0, rd_b_req = 1'b0, wr_req = 1'b0;
    logic [AW-1:0] rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [CW-1:0] swing_cycles = CW'(1);
    logic          pch_en, wl_en_a, wl_en_b, wdrv_en, sa_clk, iso_en, wr_phase, rdy;
    logic          grant_a, grant_b, grant_w;
    logic [AW-1:0] wl_row_a, wl_row_b;

    int  n_chk = 0, n_bad = 0;
    bit  finished = 0;

    always #4 clk = ~clk;

    sram_phase_seq #(.AW(AW), .CW(CW)) dut (.*);

    // behavioural cell array
    logic [7:0]    mem [2**AW];
    logic [7:0]    wdata = '0;
    logic [7:0]    cap_a, cap_b;
    logic [AW-1:0] lat_ra, lat_rb;

    function automatic logic [7:0] init_val(int r);
        return 8'(r * 7 + 3);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2**AW; i++) mem[i] <= init_val(i);
            cap_a <= '0; cap_b <= '0; lat_ra <= '0; lat_rb <= '0;
        end else begin
            if (wl_en_a && !wdrv_en) lat_ra <= wl_row_a;
            if (wl_en_b) lat_rb <= wl_row_b;
            if (sa_clk) begin
                cap_a <= mem[lat_ra];
                cap_b <= mem[lat_rb];
            end
            if (wl_en_a && wdrv_en) mem[wl_row_a] <= wdata;
        end
    end

    function automatic logic [31:0] act_vec();
        return {9'd0, pch_en, wl_en_a, wl_en_b, wdrv_en, sa_clk, iso_en, wr_phase,
                rdy, grant_a, grant_b, grant_w, wl_row_a, wl_row_b};
    endfunction

    function automatic logic [31:0] exp_vec(int i, bit a, bit b, bit w, int n,
                                            logic [AW-1:0] ra, logic [AW-1:0] rb,
                                            logic [AW-1:0] rw);
        logic pch = 0, wla = 0, wlb = 0, drv = 0, sa = 0, iso = 0, ph = 0, rd = 0;
        logic [AW-1:0] oa = '0, ob = '0;
        int base = 0;
        int last;
        if (a || b) begin
            if (i == 1) pch = 1;
            else if (i <= n + 1) begin
                wla = a; wlb = b;
                oa = a ? ra : '0; ob = b ? rb : '0;
            end else if (i == n + 2) begin
                sa = 1; iso = 1;
            end
            base = n + 2;
        end
        if (w) begin
            if (i == base + 1) begin drv = 1; ph = 1; end
            else if (i > base + 1 && i <= base + n + 1) begin
                drv = 1; ph = 1; wla = 1; oa = rw;
            end
        end
        last = w ? base + n + 1 : base;
        if (i == last + 1) rd = 1;
        return {9'd0, pch, wla, wlb, drv, sa, iso, ph, rd,
                logic'(i == 1 && a), logic'(i == 1 && b), logic'(i == 1 && w), oa, ob};
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // walks a whole sequence; first cycle is the next falling edge after gap idle ones
    task automatic run_seq(string tag, bit a, bit b, bit w, int n,
                           logic [AW-1:0] ra, logic [AW-1:0] rb, logic [AW-1:0] rw,
                           int gap);
        int total;
        total = ((a || b) ? n + 2 : 0) + (w ? n + 1 : 0) + 1;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check({tag, " idle gap R10"}, act_vec(), 32'd0);
        end
        for (int i = 1; i <= total; i++) begin
            @(negedge clk);
            check(tag, act_vec(), exp_vec(i, a, b, w, n, ra, rb, rw));
            check("R11 precharge with wordline", 32'(pch_en && (wl_en_a || wl_en_b)), 32'd0);
            if (i == 1) begin
                if (a) rd_a_req = 1'b0;
                if (b) rd_b_req = 1'b0;
                if (w) wr_req = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 in reset", act_vec(), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", act_vec(), 32'd0);
    endtask

    task automatic t_single_read();
        swing_cycles = 4'd3; rd_a_addr = 6'd5; rd_a_req = 1'b1;
        run_seq("R2 R4 R6 read", 1, 0, 0, 3, 6'd5, 0, 0, 0);
        check("R2 read data", 32'(cap_a), 32'(init_val(5)));
        @(negedge clk);
    endtask

    task automatic t_single_write();
        swing_cycles = 4'd2; wr_addr = 6'd9; wdata = 8'hC3; wr_req = 1'b1;
        run_seq("R3 write", 0, 0, 1, 2, 0, 0, 6'd9, 0);
        @(negedge clk);
        rd_a_addr = 6'd9; rd_a_req = 1'b1;
        run_seq("R3 readback", 1, 0, 0, 2, 6'd9, 0, 0, 0);
        check("R3 written data", 32'(cap_a), 32'hC3);
        @(negedge clk);
    endtask

    task automatic t_swing_edges();
        swing_cycles = 4'd0; rd_a_addr = 6'd1; rd_a_req = 1'b1;
        run_seq("R5 swing zero", 1, 0, 0, 1, 6'd1, 0, 0, 0);
        check("R5 data", 32'(cap_a), 32'(init_val(1)));
        @(negedge clk);
        swing_cycles = 4'd15; rd_a_addr = 6'd63; rd_a_req = 1'b1;
        run_seq("R5 swing max", 1, 0, 0, 15, 6'd63, 0, 0, 0);
        check("R5 max data", 32'(cap_a), 32'(init_val(63)));
        @(negedge clk);
    endtask

    task automatic t_priority();
        swing_cycles = 4'd2; rd_a_addr = 6'd2; wr_addr = 6'd2; wdata = 8'h11;
        rd_a_req = 1'b1; wr_req = 1'b1;
        run_seq("R7 read first", 1, 0, 0, 2, 6'd2, 0, 0, 0);
        check("R7 read before write data", 32'(cap_a), 32'(init_val(2)));
        run_seq("R10 held write", 0, 0, 1, 2, 0, 0, 6'd2, 1);
        @(negedge clk);
        rd_a_req = 1'b1;
        run_seq("R10 readback", 1, 0, 0, 2, 6'd2, 0, 0, 0);
        check("R10 write not lost", 32'(cap_a), 32'h11);
        @(negedge clk);
    endtask

    task automatic t_ignore_b();
        rd_b_addr = 6'd7; rd_b_req = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R7 port B ignored in single mode", act_vec(), 32'd0);
        end
        rd_a_addr = 6'd3; rd_a_req = 1'b1; swing_cycles = 4'd1;
        run_seq("R7 B ignored beside A", 1, 0, 0, 1, 6'd3, 0, 0, 0);
        rd_b_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_dual();
        dual_mode = 1'b1; swing_cycles = 4'd2;
        rd_a_addr = 6'd9; rd_b_addr = 6'd5; wr_addr = 6'd9; wdata = 8'h77;
        rd_a_req = 1'b1; rd_b_req = 1'b1; wr_req = 1'b1;
        run_seq("R8 dual reads then write", 1, 1, 1, 2, 6'd9, 6'd5, 6'd9, 0);
        check("R9 same row old data", 32'(cap_a), 32'hC3);
        check("R8 port B data", 32'(cap_b), 32'(init_val(5)));
        @(negedge clk);
        rd_b_addr = 6'd9; rd_b_req = 1'b1; swing_cycles = 4'd3;
        run_seq("R8 dual B only", 0, 1, 0, 3, 0, 6'd9, 0, 0);
        check("R9 write landed", 32'(cap_b), 32'h77);
        @(negedge clk);
        wr_addr = 6'd4; wdata = 8'h5A; wr_req = 1'b1;
        run_seq("R8 dual write only", 0, 0, 1, 3, 0, 0, 6'd4, 0);
        @(negedge clk);
        dual_mode = 1'b0;
    endtask

    initial begin
        t_reset();
        t_single_read();
        t_single_write();
        t_swing_edges();
        t_priority();
        t_ignore_b();
        t_dual();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule